// File: doc/BRIEF.md
# Serial LED Status Shifter

This block carries hub status out to external shift-register LED drivers. Four serial data lines share one shift clock and one latch strobe. The lines carry:

- the link/receive state of each twisted-pair port,
- the partition state of each twisted-pair port,
- the error state of the two attachment-unit ports,
- a utilization bar graph.

Every status bit is active low. Each line sends an 8-bit word, most significant bit first. One latch slot follows each word. The external latch captures the word on the shift-clock rising edge that falls inside that slot.

The block also holds two pieces of status logic. The first is a receive-activity stretcher for each port, which turns a packet start into a fixed blink timed by a millisecond tick. The second is an encoder that turns a utilization measure into an eight-level thermometer with non-uniform steps. The status words are sampled once, at the start of each frame, so a frame never mixes old and new values. The bandwidth measurement itself comes from outside the block.

Top module: `led_status_serializer`

## Requirements
- R1: The shift clock has a period of 2*SCLK_HALF system clocks. A frame lasts 9 shift-clock periods: 8 data slots carry bit 7 first and bit 0 last, and a latch slot follows. Every data line is held high during the latch slot.
- R2: The data lines and the latch line change only on the system clock edge where the shift clock falls.
- R3: The latch line is high for exactly one shift-clock period per frame. It therefore covers exactly one rising edge, and that edge comes after the 8 data rising edges.
- R4: In the partition word (`part_ser_o`), bit n is low when `part_i[n]` is 1 and high otherwise.
- R5: In the link word (`link_ser_o`), bit n is low when `link_ok_i[n]` is 1 and port n is not blinking. Bit n is high when `link_ok_i[n]` is 0.
- R6: A clock with `rx_start_i[n]` high, while port n's stretcher is idle, drives link bit n high for exactly ON_MS rising edges of `ms_tick_i` (default 78). The bit then stays low for OFF_MS ticks (default 52). A packet start during either phase is ignored.
- R7: `util_i` is measured in units of 1/UTIL_FULL of the bandwidth (default 1600). In the utilization word, bit k is low when `util_i` is strictly greater than threshold k. The thresholds are 1%, 6.25%, 12.5%, 25%, 37.5%, 50%, 62.5% and 87.5% of UTIL_FULL, which is 16, 100, 200, 400, 600, 800, 1000 and 1400 at the default.
- R8: In the attachment-unit word, bits 0 to 3 report port index 0 and bits 4 to 7 report port index 1. Within each nibble the order from low bit to high is: partition, rate error, jabber, loopback error. Each bit is low when its input is 1.
- R9: While reset is held, the latch line and the shift clock are low and every data line is high.
- R10: All four words are sampled on the shift-clock fall that starts data slot 0. An input change later in the frame first shows up in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| link_ok_i | input | NPORTS | 1 = link pass on port n |
| rx_start_i | input | NPORTS | 1 = packet start seen on port n |
| part_i | input | NPORTS | 1 = port n partitioned |
| aui_part_i | input | 2 | Attachment-unit port partitioned |
| aui_rate_err_i | input | 2 | Attachment-unit port bit rate error |
| aui_jabber_i | input | 2 | Attachment-unit port jabber |
| aui_loop_err_i | input | 2 | Attachment-unit port loopback error |
| util_i | input | UTIL_W | Utilization in units of 1/UTIL_FULL |
| shift_clk_o | output | 1 | Shared serial shift clock |
| latch_o | output | 1 | Word latch strobe |
| link_ser_o | output | 1 | Link/receive serial line |
| part_ser_o | output | 1 | Partition serial line |
| aui_ser_o | output | 1 | Attachment-unit status serial line |
| util_ser_o | output | 1 | Utilization bar serial line |

## Verification
The bench targets the boundaries of the blink timer: the last on tick, the first off tick and the return to idle. A stretcher that is off by one tick, or that can be retriggered while off, shows the wrong link bit after exactly ON_MS or OFF_MS ticks. The utilization encoder is driven exactly at each threshold and one unit above it, so a comparison with `>=` where `>` is required produces a word shifted by one level. Asymmetric partition and attachment-unit patterns expose a reversed bit order or a swapped nibble. An input change in the middle of a frame must leave that frame intact; sampling the inputs live would latch a mixed word.

// File: rtl/led_status_pkg.sv
// Shared definitions for the serial LED status shifter.
package led_status_pkg;

    // Number of serial data lines, one for each kind of status word.
    localparam int LANES = 4;

    // Lane positions inside the packed word array.
    localparam int LANE_LINK = 0;
    localparam int LANE_PART = 1;
    localparam int LANE_AUI  = 2;
    localparam int LANE_UTIL = 3;

    // States of the receive-activity stretcher.
    typedef enum logic [1:0] {
        BL_IDLE = 2'd0,
        BL_ON   = 2'd1,
        BL_OFF  = 2'd2
    } blink_st_t;

    // Threshold of utilization level k, given a full-scale value.
    function automatic int unsigned util_thresh(input int unsigned k,
                                                input int unsigned full);
        case (k)
            0:       return full / 100;
            1:       return full / 16;
            2:       return full / 8;
            3:       return full / 4;
            4:       return (full * 3) / 8;
            5:       return full / 2;
            6:       return (full * 5) / 8;
            default: return (full * 7) / 8;
        endcase
    endfunction

endpackage

// File: rtl/led_shift_clock.sv
// Shift clock generator.
// Divides the system clock down to a shift clock of period 2*SCLK_HALF.
// fall_o goes high in the cycle whose closing edge drives the shift clock low.
// Assumes SCLK_HALF >= 1.
module led_shift_clock #(
    parameter int SCLK_HALF = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic sclk_o,
    output logic fall_o
);
    localparam int DW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

    logic [DW-1:0] div_q;
    logic          sclk_q;
    logic          wrap;

    // Half-period boundary detect.
    assign wrap = (div_q == DW'(SCLK_HALF - 1));

    // Divider counter and shift clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            div_q  <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end

    assign sclk_o = sclk_q;
    assign fall_o = wrap & sclk_q;

endmodule

// File: rtl/rx_blink_stretcher.sv
// Receive-activity pulse stretcher for one port.
// A packet start seen while idle gives ON_MS ms ticks of blink, then OFF_MS
// ticks of enforced dark. Packet starts during either phase are ignored.
// Assumes ms_tick_i is a one-cycle pulse and ON_MS, OFF_MS >= 1.
module rx_blink_stretcher
    import led_status_pkg::*;
#(
    parameter int ON_MS  = 78,
    parameter int OFF_MS = 52
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick_i,
    input  logic rx_i,
    output logic blink_o
);
    localparam int MAXT = (ON_MS > OFF_MS) ? ON_MS : OFF_MS;
    localparam int CW   = $clog2(MAXT + 1);

    blink_st_t       st_q;
    logic [CW-1:0]   cnt_q;

    // Phase sequencing and millisecond counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BL_IDLE;
            cnt_q <= '0;
        end else begin
            case (st_q)
                BL_IDLE: begin
                    if (rx_i) begin
                        st_q  <= BL_ON;
                        cnt_q <= '0;
                    end
                end
                BL_ON: begin
                    if (ms_tick_i) begin
                        if (cnt_q == CW'(ON_MS - 1)) begin
                            st_q  <= BL_OFF;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                BL_OFF: begin
                    if (ms_tick_i) begin
                        if (cnt_q == CW'(OFF_MS - 1)) begin
                            st_q  <= BL_IDLE;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    st_q  <= BL_IDLE;
                    cnt_q <= '0;
                end
            endcase
        end
    end

    assign blink_o = (st_q == BL_ON);

    // R6: the on phase is always followed by the dark phase.
    p_on_then_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == BL_ON && st_q != BL_ON) |-> st_q == BL_OFF)
        else $error("p_on_then_off_r6");

    // R6: a blink only starts from idle, never out of the dark phase.
    p_start_from_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == BL_ON && $past(st_q) != BL_ON) |-> $past(st_q) == BL_IDLE)
        else $error("p_start_from_idle_r6");

endmodule

// File: rtl/util_bar_encoder.sv
// Utilization thermometer encoder.
// Bit k of bar_n_o is low when util_i is strictly above threshold k.
// The thresholds rise in non-uniform steps, from 1% up to 87.5% of UTIL_FULL.
// Assumes UTIL_FULL fits in UTIL_W bits and LEVELS == 8.
module util_bar_encoder
    import led_status_pkg::*;
#(
    parameter int UTIL_W    = 11,
    parameter int UTIL_FULL = 1600,
    parameter int LEVELS    = 8
) (
    input  logic [UTIL_W-1:0] util_i,
    output logic [LEVELS-1:0] bar_n_o
);
    // One comparator per level, each against its own constant threshold.
    for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
        localparam logic [UTIL_W-1:0] THR = UTIL_W'(util_thresh(k, UTIL_FULL));
        assign bar_n_o[k] = ~(util_i > THR);
    end

    // R7: the active levels always form a contiguous run from bit 0.
    logic [LEVELS-1:0] act;
    always_comb begin
        act = ~bar_n_o;
        p_thermo_r7: assert ((act & (act + 1'b1)) == '0)
            else $error("p_thermo_r7");
    end

endmodule

// File: rtl/led_frame_shifter.sv
// Frame shifter shared by all serial lanes.
// On each shift-clock fall, steps to the next slot. The 8 data slots go out
// MSB first and a latch slot follows. The words are loaded when slot 0 begins.
// Assumes fall_i comes from led_shift_clock and FW >= 2.
module led_frame_shifter #(
    parameter int LANES = 4,
    parameter int FW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fall_i,
    input  logic [LANES-1:0][FW-1:0]   word_i,
    output logic [LANES-1:0]           ser_o,
    output logic                       latch_o
);
    localparam int SW   = $clog2(FW + 1);
    localparam int LAST = FW;

    logic [SW-1:0] slot_q;
    logic [SW-1:0] slot_n;
    logic          latch_q;
    logic [LANES-1:0] ser_q;

    // Next slot index, wrapping from the latch slot to data slot 0.
    assign slot_n = (slot_q == SW'(LAST)) ? '0 : slot_q + 1'b1;

    // Slot counter and latch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= SW'(LAST);
            latch_q <= 1'b0;
        end else if (fall_i) begin
            slot_q  <= slot_n;
            latch_q <= (slot_n == SW'(LAST));
        end
    end

    // One shift register per lane: load at slot 0, shift ones in behind.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [FW-1:0] sh_q;

        // Serial output and shift register update of lane g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q     <= '1;
                ser_q[g] <= 1'b1;
            end else if (fall_i) begin
                if (slot_n == '0) begin
                    ser_q[g] <= word_i[g][FW-1];
                    sh_q     <= {word_i[g][FW-2:0], 1'b1};
                end else begin
                    ser_q[g] <= sh_q[FW-1];
                    sh_q     <= {sh_q[FW-2:0], 1'b1};
                end
            end
        end
    end

    assign ser_o   = ser_q;
    assign latch_o = latch_q;

    // R1: every data line is idle high during the latch slot.
    p_latch_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        latch_q |-> (&ser_q))
        else $error("p_latch_fill_r1");

    // R3: the latch drops only when the shift clock steps to a new slot.
    p_latch_on_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latch_q) |-> $past(fall_i))
        else $error("p_latch_on_step_r3");

endmodule

// File: rtl/led_status_serializer.sv
// Serial LED status shifter, top level.
// Assembles the four active-low status words (link/receive, partition,
// attachment-unit errors, utilization bar) and shifts them out on four lines
// that share one shift clock and one latch strobe.
// Assumes NPORTS == 8 (one word bit per port) and a one-cycle ms_tick_i.
module led_status_serializer
    import led_status_pkg::*;
#(
    parameter int NPORTS    = 8,
    parameter int SCLK_HALF = 1,
    parameter int ON_MS     = 78,
    parameter int OFF_MS    = 52,
    parameter int UTIL_W    = 11,
    parameter int UTIL_FULL = 1600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ms_tick_i,
    input  logic [NPORTS-1:0] link_ok_i,
    input  logic [NPORTS-1:0] rx_start_i,
    input  logic [NPORTS-1:0] part_i,
    input  logic [1:0]        aui_part_i,
    input  logic [1:0]        aui_rate_err_i,
    input  logic [1:0]        aui_jabber_i,
    input  logic [1:0]        aui_loop_err_i,
    input  logic [UTIL_W-1:0] util_i,
    output logic              shift_clk_o,
    output logic              latch_o,
    output logic              link_ser_o,
    output logic              part_ser_o,
    output logic              aui_ser_o,
    output logic              util_ser_o
);
    localparam int FW = NPORTS;

    logic                      fall;
    logic [NPORTS-1:0]         blink;
    logic [FW-1:0]             util_bar_n;
    logic [LANES-1:0][FW-1:0]  words;
    logic [LANES-1:0]          ser;

    // Shift clock and slot stepping strobe.
    led_shift_clock #(.SCLK_HALF(SCLK_HALF)) i_sclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_o (shift_clk_o),
        .fall_o (fall)
    );

    // One receive-activity stretcher per port.
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        rx_blink_stretcher #(.ON_MS(ON_MS), .OFF_MS(OFF_MS)) i_blink (
            .clk       (clk),
            .rst_n     (rst_n),
            .ms_tick_i (ms_tick_i),
            .rx_i      (rx_start_i[p]),
            .blink_o   (blink[p])
        );
    end

    // Utilization thermometer.
    util_bar_encoder #(.UTIL_W(UTIL_W), .UTIL_FULL(UTIL_FULL), .LEVELS(FW)) i_util (
        .util_i  (util_i),
        .bar_n_o (util_bar_n)
    );

    // Word assembly, every bit active low.
    always_comb begin
        words[LANE_LINK] = ~link_ok_i | blink;
        words[LANE_PART] = ~part_i;
        words[LANE_AUI]  = ~{aui_loop_err_i[1], aui_jabber_i[1], aui_rate_err_i[1], aui_part_i[1],
                             aui_loop_err_i[0], aui_jabber_i[0], aui_rate_err_i[0], aui_part_i[0]};
        words[LANE_UTIL] = util_bar_n;
    end

    // Framing and serialization of all lanes.
    led_frame_shifter #(.LANES(LANES), .FW(FW)) i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall),
        .word_i  (words),
        .ser_o   (ser),
        .latch_o (latch_o)
    );

    assign link_ser_o = ser[LANE_LINK];
    assign part_ser_o = ser[LANE_PART];
    assign aui_ser_o  = ser[LANE_AUI];
    assign util_ser_o = ser[LANE_UTIL];

    // R2: serial outputs move only together with a falling shift clock.
    p_data_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({link_ser_o, part_ser_o, aui_ser_o, util_ser_o, latch_o})
        |-> $fell(shift_clk_o))
        else $error("p_data_on_fall_r2");

    // R9: reset leaves every output inactive.
    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> (!latch_o && !shift_clk_o &&
                    (&{link_ser_o, part_ser_o, aui_ser_o, util_ser_o})))
        else $error("p_reset_idle_r9");

endmodule

// File: tb/test_led_status_serializer.sv
module test_led_status_serializer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic [7:0]  link_ok = 8'hFF;
    logic [7:0]  rx_start = 8'h00;
    logic [7:0]  part = 8'h00;
    logic [1:0]  a_part = 2'b00, a_rate = 2'b00, a_jab = 2'b00, a_loop = 2'b00;
    logic [10:0] util = 11'd0;
    logic        sclk, latch, s_link, s_part, s_aui, s_util;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    led_status_serializer i_led_status_serializer (
        .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick),
        .link_ok_i(link_ok), .rx_start_i(rx_start), .part_i(part),
        .aui_part_i(a_part), .aui_rate_err_i(a_rate), .aui_jabber_i(a_jab),
        .aui_loop_err_i(a_loop), .util_i(util),
        .shift_clk_o(sclk), .latch_o(latch),
        .link_ser_o(s_link), .part_ser_o(s_part), .aui_ser_o(s_aui), .util_ser_o(s_util)
    );

    // Model of the external shift registers and latches
    logic [7:0] sr_link, sr_part, sr_aui, sr_util;
    logic [7:0] cap_link, cap_part, cap_aui, cap_util;
    int frames = 0, rise_cnt = 0, bits_last = -1, viol = 0;
    int cyc = 0, last_rise = 0, rise_gap = 0;
    logic prev_sclk = 1'b0;
    logic [4:0] prev_out = 5'b11110;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if ({s_link, s_part, s_aui, s_util, latch} != prev_out && !(prev_sclk && !sclk))
                viol++;
            if (sclk && !prev_sclk) begin
                rise_gap = cyc - last_rise;
                last_rise = cyc;
                if (latch) begin
                    cap_link = sr_link; cap_part = sr_part;
                    cap_aui = sr_aui; cap_util = sr_util;
                    bits_last = rise_cnt;
                    rise_cnt = 0;
                    frames++;
                end else begin
                    sr_link = {sr_link[6:0], s_link};
                    sr_part = {sr_part[6:0], s_part};
                    sr_aui  = {sr_aui[6:0], s_aui};
                    sr_util = {sr_util[6:0], s_util};
                    rise_cnt++;
                end
            end
        end
        prev_sclk = sclk;
        prev_out = {s_link, s_part, s_aui, s_util, latch};
    end

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_frames(input int n);
        int start = frames;
        while (frames < start + n) @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk) ms_tick = 1'b1;
        @(negedge clk) ms_tick = 1'b0;
    endtask

    task automatic rx_pulse(input int p);
        @(negedge clk) rx_start[p] = 1'b1;
        @(negedge clk) rx_start[p] = 1'b0;
    endtask

    task automatic t_reset();
        repeat (5) @(negedge clk);
        check_eq("R9 latch low in reset", int'(latch), 0);
        check_eq("R9 shift clock low in reset", int'(sclk), 0);
        check_eq("R9 data lines high in reset", int'({s_link, s_part, s_aui, s_util}), 4'hF);
        @(negedge clk) rst_n = 1'b1;
    endtask

    task automatic t_frame_shape();
        wait_frames(3);
        check_eq("R1 R3 data rises per frame", bits_last, 8);
        check_eq("R1 shift clock period", rise_gap, 2);
        check_eq("R2 outputs change only at shift clock fall", viol, 0);
        check_eq("R5 all links pass", int'(cap_link), 8'h00);
        check_eq("R7 zero utilization", int'(cap_util), 8'hFF);
    endtask

    task automatic t_partition();
        part = 8'h01; wait_frames(2);
        check_eq("R4 R1 port0 partitioned", int'(cap_part), 8'hFE);
        part = 8'hA0; wait_frames(2);
        check_eq("R4 ports 5 and 7 partitioned", int'(cap_part), 8'h5F);
        part = 8'h00;
    endtask

    task automatic t_link();
        link_ok = 8'hF0; wait_frames(2);
        check_eq("R5 low ports fail", int'(cap_link), 8'h0F);
        link_ok = 8'hFF; wait_frames(2);
        check_eq("R5 all pass again", int'(cap_link), 8'h00);
    endtask

    task automatic t_aui();
        a_part = 2'b01; wait_frames(2);
        check_eq("R8 port index0 partition", int'(cap_aui), 8'hFE);
        a_part = 2'b00; a_loop = 2'b10; wait_frames(2);
        check_eq("R8 port index1 loopback", int'(cap_aui), 8'h7F);
        a_loop = 2'b00; a_rate = 2'b10; a_jab = 2'b01; wait_frames(2);
        check_eq("R8 rate error index1, jabber index0", int'(cap_aui), 8'hDB);
        a_rate = 2'b00; a_jab = 2'b00;
    endtask

    task automatic t_util();
        int vals [10] = '{16, 17, 100, 101, 200, 801, 1000, 1400, 1401, 0};
        int exps [10] = '{8'hFF, 8'hFE, 8'hFE, 8'hFC, 8'hFC, 8'hC0, 8'hC0, 8'h80, 8'h00, 8'hFF};
        for (int i = 0; i < 10; i++) begin
            util = 11'(vals[i]); wait_frames(2);
            check_eq($sformatf("R7 utilization %0d", vals[i]), int'(cap_util), exps[i]);
        end
    endtask

    task automatic t_blink();
        rx_pulse(3); wait_frames(2);
        check_eq("R6 blink starts", int'(cap_link), 8'h08);
        for (int i = 0; i < 77; i++) tick();
        rx_pulse(3);
        wait_frames(2);
        check_eq("R6 still on after ON_MS-1 ticks", int'(cap_link), 8'h08);
        tick(); wait_frames(2);
        check_eq("R6 dark after ON_MS ticks", int'(cap_link), 8'h00);
        rx_pulse(3); wait_frames(2);
        check_eq("R6 packet ignored while dark", int'(cap_link), 8'h00);
        for (int i = 0; i < 51; i++) tick();
        wait_frames(2);
        check_eq("R6 dark for OFF_MS-1 ticks", int'(cap_link), 8'h00);
        tick();
        rx_pulse(3); wait_frames(2);
        check_eq("R6 responds after OFF_MS ticks", int'(cap_link), 8'h08);
        link_ok[5] = 1'b0; wait_frames(2);
        check_eq("R5 R6 fail and blink together", int'(cap_link), 8'h28);
        link_ok[5] = 1'b1;
        for (int i = 0; i < 130; i++) tick();
    endtask

    task automatic t_snapshot();
        int f;
        part = 8'h00; wait_frames(2);
        f = frames;
        while (frames < f + 1) @(negedge clk);
        while (rise_cnt < 4) @(negedge clk);
        part = 8'hFF;
        while (frames < f + 2) @(negedge clk);
        check_eq("R10 frame keeps its starting snapshot", int'(cap_part), 8'hFF);
        while (frames < f + 3) @(negedge clk);
        check_eq("R10 change shows in next frame", int'(cap_part), 8'h00);
        part = 8'h00;
    endtask

    initial begin
        t_reset();
        t_frame_shape();
        t_partition();
        t_link();
        t_aui();
        t_util();
        t_blink();
        t_snapshot();
        check_eq("R2 no off-edge output change", viol, 0);
        check_eq("R3 latch covers one rise", bits_last, 8);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule